// File: doc/BRIEF.md
# Low-Speed Oscillator Control Register

This block is the control and status register for a 32 kHz external low-speed oscillator and the clock-security monitor that watches it. Software reaches it through one write port and a read word on the bus clock. The register holds an oscillator enable, a bypass select, a two-bit drive-strength field, a monitor enable and a sticky failure flag. It also reports a ready flag that is derived in the oscillator clock domain.

Each field accepts software writes under its own rule:
- The bypass select changes only while the oscillator is off.
- The drive field freezes once software has written the lowest setting.
- The monitor enable can be set only when both low-speed oscillators report enabled and ready. Software can clear it only after a failure has been flagged.
- The ready flag falls only after a fixed number of oscillator cycles have passed with the enable cleared. It is then returned to the bus clock through a synchronizer.

Two resets clear every field: the asynchronous power-on reset `rst_ni` and a synchronous domain software reset `dom_rst_i`.

Top module: `lso_ctrl_reg`

## Requirements
- R1: Power-on reset and a one-cycle `dom_rst_i` both clear every field, so the read word is 0 on the bus cycle after the reset.
- R2: Bit 8 is the oscillator enable (1 = on). Every register write loads it freely.
- R3: Bit 10 is the bypass select. A write loads it only if bit 8 read 0 before that write; otherwise it keeps its value.
- R4: Bits 12:11 hold the drive strength, from 00 (lowest) to 11 (highest). After any write that carries 00 in this field, the field ignores all writes until one of the two resets.
- R5: Bit 13 is the monitor enable. A write of 1 sets it only if bit 8, bit 9, `int_en_i` and `int_rdy_i` are all 1; otherwise the write is dropped.
- R6: Once bit 13 is set, a write of 0 clears it only while bit 14 reads 1.
- R7: Bit 14 is the failure flag. A `fail_pulse_i` pulse sets it only while bit 13 is 1; pulses while bit 13 is 0 are ignored. Software writes have no effect on it, and only the resets clear it.
- R8: Bit 9 is the read-only ready flag. It rises after bit 8 is 1 and `osc_stable_i` is high, and it never rises while bit 8 is 0.
- R9: After bit 8 is cleared, ready stays 1 for at least 6 cycles of `osc_clk_i` before it falls.
- R10: Bits other than 8 to 14 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| dom_rst_i | input | 1 | Domain software reset, synchronous to clk_i, active high |
| osc_clk_i | input | 1 | Low-speed oscillator clock |
| osc_stable_i | input | 1 | Oscillator stability indication, osc_clk_i domain |
| fail_pulse_i | input | 1 | Failure pulse from the security monitor, clk_i domain |
| int_en_i | input | 1 | Internal low-speed oscillator enabled |
| int_rdy_i | input | 1 | Internal low-speed oscillator ready |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read word |

## Verification
Field writes, failure pulses and the domain reset show in `rdata_o` one bus edge after they are applied. The bench therefore samples on the falling edge after that edge, or later.

Ready is due several oscillator cycles after an enable change, plus a synchronizer in each direction. For this reason the bench holds each ready-dependent check for 100 bus cycles (about 16 oscillator periods). The lower bound of R9 is sampled 30 bus cycles (5 oscillator periods) after the clearing write, which is earlier than the earliest legal fall. A checker in the oscillator domain counts cycles with the synchronized enable low and requires at least 6 before ready falls.

// File: rtl/lso_pkg.sv
package lso_pkg;
  localparam int EN_BIT   = 8;
  localparam int RDY_BIT  = 9;
  localparam int BYP_BIT  = 10;
  localparam int DRV_LSB  = 11;
  localparam int DRV_W    = 2;
  localparam int MON_BIT  = 13;
  localparam int FAIL_BIT = 14;

  typedef logic [DRV_W-1:0] drv_t;
  localparam drv_t DRV_LOCK_VAL = '0;
endpackage

// File: rtl/lso_sync.sv
module lso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lso_ready_ctrl.sv
module lso_ready_ctrl #(
  parameter int OFF_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic en_i,        // bus domain
  input  logic stable_i,
  output logic en_sync_o,
  output logic rdy_o        // osc domain
);
  localparam int CNT_W = $clog2(OFF_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OFF_CYCLES - 1);

  logic en_s, rdy_q;
  logic [CNT_W-1:0] cnt_q;

  lso_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_s)
  );

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (en_s) begin
      rdy_q <= stable_i;
      cnt_q <= '0;
    end else if (rdy_q) begin
      // hold ready for OFF_CYCLES osc edges after disable
      if (cnt_q == LAST) begin
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign en_sync_o = en_s;
  assign rdy_o     = rdy_q;
endmodule

// File: rtl/lso_field_regs.sv
module lso_field_regs
  import lso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dom_rst_i,
  input  logic wr_en_i,
  input  logic wr_en_bit_i,
  input  logic wr_byp_i,
  input  drv_t wr_drv_i,
  input  logic wr_mon_i,
  input  logic rdy_i,
  input  logic int_en_i,
  input  logic int_rdy_i,
  input  logic fail_pulse_i,
  output logic en_o,
  output logic byp_o,
  output drv_t drv_o,
  output logic mon_o,
  output logic fail_o
);
  logic en_q, byp_q, mon_q, fail_q, lock_q;
  drv_t drv_q;
  logic mon_gate;

  assign mon_gate = en_q & rdy_i & int_en_i & int_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      drv_q  <= '0;
      lock_q <= 1'b0;
      mon_q  <= 1'b0;
      fail_q <= 1'b0;
    end else if (dom_rst_i) begin
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      drv_q  <= '0;
      lock_q <= 1'b0;
      mon_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        en_q <= wr_en_bit_i;
        if (!en_q) byp_q <= wr_byp_i;
        if (!lock_q) begin
          drv_q  <= wr_drv_i;
          lock_q <= (wr_drv_i == DRV_LOCK_VAL);
        end
        if (wr_mon_i && !mon_q && mon_gate)      mon_q <= 1'b1;
        else if (!wr_mon_i && mon_q && fail_q)   mon_q <= 1'b0;
      end
      if (fail_pulse_i && mon_q) fail_q <= 1'b1;
    end
  end

  assign en_o   = en_q;
  assign byp_o  = byp_q;
  assign drv_o  = drv_q;
  assign mon_o  = mon_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/lso_ctrl_reg.sv
module lso_ctrl_reg
  import lso_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int OFF_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dom_rst_i,
  input  logic              osc_clk_i,
  input  logic              osc_stable_i,
  input  logic              fail_pulse_i,
  input  logic              int_en_i,
  input  logic              int_rdy_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << (FAIL_BIT + 1)) - (1 << EN_BIT));

  logic en, byp, mon, fail;
  drv_t drv;
  logic en_osc, rdy_osc, rdy_sync, rdy_q;

  lso_field_regs u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dom_rst_i   (dom_rst_i),
    .wr_en_i     (wr_en_i),
    .wr_en_bit_i (wdata_i[EN_BIT]),
    .wr_byp_i    (wdata_i[BYP_BIT]),
    .wr_drv_i    (wdata_i[DRV_LSB +: DRV_W]),
    .wr_mon_i    (wdata_i[MON_BIT]),
    .rdy_i       (rdy_q),
    .int_en_i    (int_en_i),
    .int_rdy_i   (int_rdy_i),
    .fail_pulse_i(fail_pulse_i),
    .en_o        (en),
    .byp_o       (byp),
    .drv_o       (drv),
    .mon_o       (mon),
    .fail_o      (fail)
  );

  lso_ready_ctrl #(
    .OFF_CYCLES (OFF_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ready (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .stable_i (osc_stable_i),
    .en_sync_o(en_osc),
    .rdy_o    (rdy_osc)
  );

  lso_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_osc),
    .q_o   (rdy_sync)
  );

  // ready may hold or fall while disabled, never rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_q <= 1'b0;
    else if (dom_rst_i) rdy_q <= 1'b0;
    else                rdy_q <= rdy_sync & (en | rdy_q);
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[EN_BIT]                = en;
    rdata_o[RDY_BIT]               = rdy_q;
    rdata_o[BYP_BIT]               = byp;
    rdata_o[DRV_LSB +: DRV_W]      = drv;
    rdata_o[MON_BIT]               = mon;
    rdata_o[FAIL_BIT]              = fail;
  end

  logic unused_wdata;
  assign unused_wdata = ^(wdata_i & ~USED_MASK) ^ wdata_i[RDY_BIT] ^ wdata_i[FAIL_BIT];
endmodule

// File: rtl/lso_ctrl_reg_chk.sv
module lso_ctrl_reg_chk
  import lso_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int OFF_CYCLES = 6
) (
  input logic              clk_i,
  input logic              osc_clk_i,
  input logic              rst_ni,
  input logic              dom_rst_i,
  input logic              wr_en_i,
  input drv_t              wr_drv_i,
  input logic              int_en_i,
  input logic              int_rdy_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              en_osc_i,
  input logic              rdy_osc_i
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << (FAIL_BIT + 1)) - (1 << EN_BIT));
  localparam int LO_W = $clog2(OFF_CYCLES + 1) + 1;

  logic lk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  lk_q <= 1'b0;
    else if (dom_rst_i)                           lk_q <= 1'b0;
    else if (wr_en_i && wr_drv_i == DRV_LOCK_VAL) lk_q <= 1'b1;
  end

  logic [LO_W-1:0] lo_cnt;
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lo_cnt <= '0;
    else if (en_osc_i)                    lo_cnt <= '0;
    else if (lo_cnt != LO_W'(OFF_CYCLES)) lo_cnt <= lo_cnt + 1'b1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_rst_i |=> rdata_o == '0);

  assert_byp_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o[BYP_BIT]) |-> (!$past(rdata_o[EN_BIT]) || $past(dom_rst_i)));

  assert_drv_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_q && !dom_rst_i) |=> $stable(rdata_o[DRV_LSB +: DRV_W]));

  assert_mon_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[MON_BIT]) |-> $past(rdata_o[EN_BIT] & rdata_o[RDY_BIT] & int_en_i & int_rdy_i));

  assert_mon_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[MON_BIT]) |-> ($past(rdata_o[FAIL_BIT]) || $past(dom_rst_i)));

  assert_fail_needs_mon_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[FAIL_BIT]) |-> $past(rdata_o[MON_BIT]));

  assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[FAIL_BIT] && !dom_rst_i) |=> rdata_o[FAIL_BIT]);

  assert_rdy_no_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[RDY_BIT]) |-> $past(rdata_o[EN_BIT]));

  assert_rdy_hold_R9: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ($fell(rdy_osc_i) && !$past(en_osc_i)) |-> lo_cnt >= LO_W'(OFF_CYCLES));

  assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~USED_MASK) == '0);
endmodule

bind lso_ctrl_reg lso_ctrl_reg_chk #(
  .DATA_W    (DATA_W),
  .OFF_CYCLES(OFF_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .osc_clk_i(osc_clk_i),
  .rst_ni   (rst_ni),
  .dom_rst_i(dom_rst_i),
  .wr_en_i  (wr_en_i),
  .wr_drv_i (wdata_i[lso_pkg::DRV_LSB +: lso_pkg::DRV_W]),
  .int_en_i (int_en_i),
  .int_rdy_i(int_rdy_i),
  .rdata_o  (rdata_o),
  .en_osc_i (en_osc),
  .rdy_osc_i(rdy_osc)
);

// File: tb/sim_lso_ctrl_reg.sv
module sim_lso_ctrl_reg;
  logic        clk_i = 1'b0, osc_clk_i = 1'b0;
  logic        rst_ni = 1'b0, dom_rst_i = 1'b0;
  logic        osc_stable_i = 1'b1, fail_pulse_i = 1'b0;
  logic        int_en_i = 1'b1, int_rdy_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  int checks = 0, failures = 0;

  always #5  clk_i = ~clk_i;
  always #30 osc_clk_i = ~osc_clk_i;

  lso_ctrl_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .dom_rst_i(dom_rst_i), .osc_clk_i(osc_clk_i),
    .osc_stable_i(osc_stable_i), .fail_pulse_i(fail_pulse_i), .int_en_i(int_en_i),
    .int_rdy_i(int_rdy_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  // bits: 8 en, 9 rdy, 10 byp, 12:11 drv, 13 mon, 14 fail
  localparam vec_t VEC [7] = '{
    '{32'h0000_1400, 32'h0000_1400},  // R3 byp taken while off, R4 drv=10
    '{32'h0000_1D00, 32'h0000_1F00},  // R2 enable, R8 ready rises
    '{32'h0000_0900, 32'h0000_0F00},  // R3 byp clear dropped while on
    '{32'hFFFF_E9FF, 32'h0000_2F00},  // R5 mon set, R7 bit14 write ignored, R10
    '{32'h0000_0900, 32'h0000_2F00},  // R6 mon clear dropped without fail
    '{32'h0000_0000, 32'h0000_2400},  // R2 disable, R4 lock on 00, R9 ready falls
    '{32'h0000_1800, 32'h0000_2000}   // R4 drv write ignored, R3 byp clear while off
  };

  task automatic chk(input logic [31:0] exp, input string req);
    checks++;
    if (rdata_o !== exp) begin
      failures++;
      $display("FAIL %s rdata=%h expected=%h", req, rdata_o, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wdata_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    chk(32'h0, "R1 por state");
    rst_ni = 1'b1;
    idle(2);
    chk(32'h0, "R1 after por release");

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i].wdata);
      idle(100);
      chk(VEC[i].exp, $sformatf("vector %0d", i));
    end

    // R7 failure sets while monitor on
    @(negedge clk_i); fail_pulse_i = 1'b1;
    @(negedge clk_i); fail_pulse_i = 1'b0;
    chk(32'h0000_6000, "R7 fail set");
    // R6 clear allowed once failed; R7 flag stays
    wr(32'h0);
    chk(32'h0000_4000, "R6 mon clear after fail");

    // R1 domain reset clears everything, incl. drive lock
    @(negedge clk_i); dom_rst_i = 1'b1;
    @(negedge clk_i); dom_rst_i = 1'b0;
    chk(32'h0, "R1 domain reset");
    wr(32'h0000_1000);
    chk(32'h0000_1000, "R4 lock released by reset");

    // R7 pulse ignored with monitor off
    @(negedge clk_i); fail_pulse_i = 1'b1;
    @(negedge clk_i); fail_pulse_i = 1'b0;
    idle(2);
    chk(32'h0000_1000, "R7 pulse ignored");

    // R5 gating on internal oscillator status
    wr(32'h0000_1100);
    idle(100);
    chk(32'h0000_1300, "R8 ready up");
    int_rdy_i = 1'b0;
    wr(32'h0000_3100);
    idle(2);
    chk(32'h0000_1300, "R5 dropped int not ready");
    int_rdy_i = 1'b1;
    int_en_i  = 1'b0;
    wr(32'h0000_3100);
    idle(2);
    chk(32'h0000_1300, "R5 dropped int off");
    int_en_i = 1'b1;
    wr(32'h0000_3100);
    idle(2);
    chk(32'h0000_3300, "R5 accepted");

    // R9 ready holds past 5 osc cycles after disable, then falls; R8 no reassert
    wr(32'h0000_3000);
    idle(30);
    chk(32'h0000_3200, "R9 ready still high");
    idle(150);
    chk(32'h0000_3000, "R9 ready fallen");
    idle(100);
    chk(32'h0000_3000, "R8 no rise while off");

    // R1 power-on reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    idle(2);
    chk(32'h0, "R1 por mid-run");
    rst_ni = 1'b1;
    idle(2);
    chk(32'h0, "R1 after second por");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule